// File: doc/BRIEF.md
# Multi-bus I2C clock recovery sequencer

This block frees I2C target devices that hang with the data line held low after an interrupted transfer. On a start strobe it takes over the SCL pins of the buses chosen by a per-bus mask. It then sends nine full clock cycles on all of those pins together, and afterwards hands each pin back to its normal function. SCL is open drain with an external pull-up. A high level comes from releasing the line, and a low level comes from enabling the pad's low driver. The `scl_oe` output is therefore a pull-low enable and never drives high.

While a pin is overridden, its pad configuration word (function select plus control bits) is forced to a fixed "plain input, no pull" value. The normal configuration is captured when the sequence starts and is written back when the sequence ends. Buses outside the mask, and buses that have no SCL pin in this configuration, keep passing their normal output enable and configuration through a single register stage. The phase length is a cycle count sampled at start, which lets the caller keep the toggle rate below 100 kHz whatever the clock is.

Top module: `scl_recovery_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and every `bus_ovr` bit are 0.
- R2: An accepted sequence gives each overridden lane exactly nine cycles. Each cycle is a released phase (`scl_oe`=0) followed by a pull-low phase (`scl_oe`=1). Each phase lasts H clocks, where H is the sampled half period. The first released phase is visible in the cycle after the start edge, and `done` rises 18*H cycles after that.
- R3: Only lanes whose bit is set in both `bus_mask` and the `BUS_PRESENT` parameter are overridden. Bit i of the mask selects bus i. Every other lane drives `scl_oe` and `pad_cfg` from `norm_oe` and `norm_cfg` with one cycle of latency.
- R4: All overridden lanes show the same `scl_oe` value in every cycle.
- R5: A start whose effective mask is zero overrides nothing, keeps `busy` low, and pulses `done` in the next cycle.
- R6: The half period is sampled with the accepted start, and a value of 0 counts as 1. Later changes to `half_period` have no effect on the running sequence.
- R7: A start strobe that arrives while `busy` is high is ignored.
- R8: While a lane is overridden, its `pad_cfg` equals `OVR_CFG`. In the `done` cycle, its `pad_cfg` equals the `norm_cfg` value captured at start, and its `scl_oe` returns to `norm_oe`. After that the lane tracks its normal inputs again.
- R9: `done` is high for exactly one cycle. `busy` and `bus_ovr` are low in that cycle.
- R10: A lane with `BUS_PRESENT` bit 0 is never overridden, even when its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled while idle |
| bus_mask | input | NUM_BUS | Buses to recover, bit i = bus i |
| half_period | input | HALF_W | Phase length in clocks (0 counts as 1) |
| norm_oe | input | NUM_BUS | Normal-mode SCL pull-low enables |
| norm_cfg | input | NUM_BUS*CFG_W | Normal pad configuration words, bus i at bits [i*CFG_W +: CFG_W] |
| scl_oe | output | NUM_BUS | SCL pull-low enable per bus |
| bus_ovr | output | NUM_BUS | Lane is under sequencer control |
| pad_cfg | output | NUM_BUS*CFG_W | Configuration word applied to each pad |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every mask value against several half periods, including 0, with one bus marked absent. It checks every cycle of every sequence against a waveform computed from the phase index. An off-by-one in the phase or pulse counter would show as a wrong `done` cycle or a tenth low phase. Restore is checked by changing `norm_cfg` partway through a sequence: a design that restored live values instead of captured ones, or released lanes before the last low phase, would show the wrong word in the `done` cycle. A retimed start and a changed half period are applied mid-sequence, so a design that re-arms or re-samples would stretch or restart the waveform. Zero masks and absent-only masks must produce an immediate `done` with no override.

// File: rtl/scl_rec_pkg.sv
package scl_rec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/scl_rec_ctrl.sv
module scl_rec_ctrl
  import scl_rec_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PULSES = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              any_sel,
  input  logic [HALF_W-1:0] half_period,
  output logic              take,
  output logic              finish,
  output logic              low_nxt,
  output logic              busy,
  output logic              done
);
  localparam int PCW = (PULSES > 1) ? $clog2(PULSES) : 1;

  seq_state_t        state_q;
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half_q;
  logic [PCW-1:0]    pulse_q;
  logic              phase_end;
  logic              null_done;

  assign phase_end = (cnt_q == half_q - 1'b1);
  assign take      = (state_q == ST_IDLE) && start && any_sel;
  assign null_done = (state_q == ST_IDLE) && start && !any_sel;
  assign finish    = (state_q == ST_LOW) && phase_end && (pulse_q == PCW'(PULSES - 1));

  always_comb begin
    low_nxt = (state_q == ST_LOW);
    if (state_q == ST_HIGH && phase_end) low_nxt = 1'b1;
    if (state_q == ST_LOW && phase_end)  low_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= HALF_W'(1);
      pulse_q <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= finish | null_done;
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            state_q <= ST_HIGH;
            cnt_q   <= '0;
            pulse_q <= '0;
            half_q  <= (half_period == '0) ? HALF_W'(1) : half_period;
            busy    <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (phase_end) begin
            state_q <= ST_LOW;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LOW: begin
          if (finish) begin
            state_q <= ST_IDLE;
            busy    <= 1'b0;
          end else if (phase_end) begin
            state_q <= ST_HIGH;
            cnt_q   <= '0;
            pulse_q <= pulse_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R9
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    pulse_q < PCW'(PULSES));  // R2
  AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> (cnt_q < half_q));  // R2
  AST_HALF_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish) |=> $stable(half_q));  // R6
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R9
endmodule

// File: rtl/scl_rec_lane.sv
module scl_rec_lane #(
  parameter int          CFG_W   = 8,
  parameter logic [CFG_W-1:0] OVR_CFG = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             take,
  input  logic             finish,
  input  logic             low_nxt,
  input  logic             norm_oe,
  input  logic [CFG_W-1:0] norm_cfg,
  output logic             oe,
  output logic             ovr,
  output logic [CFG_W-1:0] cfg
);
  logic [CFG_W-1:0] save_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr    <= 1'b0;
      oe     <= 1'b0;
      cfg    <= '0;
      save_q <= '0;
    end else if (take && sel) begin
      save_q <= norm_cfg;
      ovr    <= 1'b1;
      oe     <= 1'b0;
      cfg    <= OVR_CFG;
    end else if (ovr) begin
      if (finish) begin
        ovr <= 1'b0;
        oe  <= norm_oe;
        cfg <= save_q;
      end else begin
        oe <= low_nxt;
      end
    end else begin
      oe  <= norm_oe;
      cfg <= norm_cfg;
    end
  end

  AST_RESTORE_SAVED: assert property (@(posedge clk) disable iff (rst)
    $fell(ovr) |-> (cfg == save_q));  // R8
  AST_OVR_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    ovr |-> (cfg == OVR_CFG));  // R8
endmodule

// File: rtl/scl_recovery_seq.sv
module scl_recovery_seq #(
  parameter int                  NUM_BUS     = 4,
  parameter int                  HALF_W      = 16,
  parameter int                  CFG_W       = 8,
  parameter int                  PULSES      = 9,
  parameter logic [NUM_BUS-1:0]  BUS_PRESENT = '1,
  parameter logic [CFG_W-1:0]    OVR_CFG     = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [NUM_BUS-1:0]       bus_mask,
  input  logic [HALF_W-1:0]        half_period,
  input  logic [NUM_BUS-1:0]       norm_oe,
  input  logic [NUM_BUS*CFG_W-1:0] norm_cfg,
  output logic [NUM_BUS-1:0]       scl_oe,
  output logic [NUM_BUS-1:0]       bus_ovr,
  output logic [NUM_BUS*CFG_W-1:0] pad_cfg,
  output logic                     busy,
  output logic                     done
);
  logic [NUM_BUS-1:0] eff_mask;
  logic take, finish, low_nxt;

  assign eff_mask = bus_mask & BUS_PRESENT;

  scl_rec_ctrl #(.HALF_W(HALF_W), .PULSES(PULSES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .any_sel(|eff_mask),
    .half_period(half_period), .take(take), .finish(finish),
    .low_nxt(low_nxt), .busy(busy), .done(done)
  );

  for (genvar i = 0; i < NUM_BUS; i++) begin : g_lane
    scl_rec_lane #(.CFG_W(CFG_W), .OVR_CFG(OVR_CFG)) u_lane (
      .clk(clk), .rst(rst), .sel(eff_mask[i]), .take(take),
      .finish(finish), .low_nxt(low_nxt), .norm_oe(norm_oe[i]),
      .norm_cfg(norm_cfg[i*CFG_W +: CFG_W]), .oe(scl_oe[i]),
      .ovr(bus_ovr[i]), .cfg(pad_cfg[i*CFG_W +: CFG_W])
    );
  end

  AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    ((scl_oe & bus_ovr) == '0) || ((scl_oe & bus_ovr) == bus_ovr));  // R4
  AST_OVR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (|bus_ovr) |-> busy);  // R3
  AST_ABSENT_NEVER: assert property (@(posedge clk) disable iff (rst)
    (bus_ovr & ~BUS_PRESENT) == '0);  // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> $stable(bus_ovr) || !busy);  // R7
endmodule

// File: tb/scl_recovery_seq_bench.sv
module scl_recovery_seq_bench;
  localparam int NB = 4;
  localparam int HW = 16;
  localparam int CW = 8;
  localparam logic [NB-1:0] PRES = 4'b0111;
  localparam logic [CW-1:0] OVR  = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NB-1:0] bus_mask = '0;
  logic [HW-1:0] half_period = '0;
  logic [NB-1:0] norm_oe = '0;
  logic [NB*CW-1:0] norm_cfg = '0;
  logic [NB-1:0] scl_oe, bus_ovr;
  logic [NB*CW-1:0] pad_cfg;
  logic busy, done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  scl_recovery_seq #(.NUM_BUS(NB), .HALF_W(HW), .CFG_W(CW), .PULSES(9),
                     .BUS_PRESENT(PRES), .OVR_CFG(OVR)) u_scl_recovery_seq (
    .clk(clk), .rst(rst), .start(start), .bus_mask(bus_mask),
    .half_period(half_period), .norm_oe(norm_oe), .norm_cfg(norm_cfg),
    .scl_oe(scl_oe), .bus_ovr(bus_ovr), .pad_cfg(pad_cfg),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NB*CW-1:0] mk_cfg(input logic [3:0] m, input bit alt);
    logic [NB*CW-1:0] v;
    for (int b = 0; b < NB; b++) v[b*CW +: CW] = alt ? ~{m, 2'(b), 2'b01} : {m, 2'(b), 2'b01};
    return v;
  endfunction

  function automatic logic [NB*CW-1:0] mix_cfg(input logic [NB-1:0] sel,
      input logic [NB*CW-1:0] a, input logic [NB*CW-1:0] b);
    logic [NB*CW-1:0] v;
    for (int k = 0; k < NB; k++) v[k*CW +: CW] = sel[k] ? a[k*CW +: CW] : b[k*CW +: CW];
    return v;
  endfunction

  task automatic run(input logic [3:0] m, input int h);
    logic [NB-1:0] eff;
    logic [NB*CW-1:0] cfg_a, cfg_b, cur, ovr_all, exp_cfg;
    logic [NB-1:0] exp_oe;
    int he;
    eff = m & PRES;
    he = (h == 0) ? 1 : h;
    cfg_a = mk_cfg(m, 1'b0);
    cfg_b = mk_cfg(m, 1'b1);
    for (int k = 0; k < NB; k++) ovr_all[k*CW +: CW] = OVR;
    bus_mask = m;
    half_period = HW'(h);
    norm_oe = ~m;
    norm_cfg = cfg_a;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cur = cfg_a;
    if (eff == '0) begin
      chk(done && !busy && bus_ovr == '0, "R5 null start done", {busy, done, bus_ovr}, 6'b010000);
      chk(scl_oe == norm_oe && pad_cfg == cfg_a, "R3/R10 passthrough on null start",
          {scl_oe, pad_cfg}, {norm_oe, cfg_a});
      @(negedge clk);
      chk(!done, "R9 done single cycle", done, 0);
      return;
    end
    for (int i = 0; i < 18*he; i++) begin
      exp_oe = (((i / he) % 2) == 1) ? (eff | (norm_oe & ~eff)) : (norm_oe & ~eff);
      chk(scl_oe == exp_oe, "R2/R4 scl_oe waveform", scl_oe, exp_oe);
      chk(bus_ovr == eff && busy && !done, "R3 override set", {bus_ovr, busy, done}, {eff, 2'b10});
      exp_cfg = mix_cfg(eff, ovr_all, cur);
      chk(pad_cfg == exp_cfg, "R8 override cfg", pad_cfg, exp_cfg);
      if (i == 1) begin
        norm_cfg = cfg_b;
        half_period = HW'(h + 3);
      end
      if (i == 2) start = 1'b1;   // R7 retimed start while busy
      if (i == 3) start = 1'b0;
      @(negedge clk);
      if (i == 1) cur = cfg_b;
    end
    exp_cfg = mix_cfg(eff, cfg_a, cfg_b);
    chk(done && !busy && bus_ovr == '0, "R9 done with busy low", {busy, done, bus_ovr}, 6'b010000);
    chk(pad_cfg == exp_cfg, "R8 restore captured cfg", pad_cfg, exp_cfg);
    chk(scl_oe == norm_oe, "R8 oe back to normal", scl_oe, norm_oe);
    @(negedge clk);
    chk(!done && !busy, "R7/R9 no second sequence", {busy, done}, 2'b00);
    chk(pad_cfg == cfg_b, "R8 tracking resumes", pad_cfg, cfg_b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && bus_ovr == '0, "R1 reset state", {busy, done, bus_ovr}, 0);
    norm_oe = 4'b1010;
    norm_cfg = mk_cfg(4'h3, 1'b0);
    @(negedge clk);
    chk(scl_oe == 4'b1010 && pad_cfg == mk_cfg(4'h3, 1'b0), "R3 idle passthrough",
        {scl_oe, pad_cfg}, {4'b1010, mk_cfg(4'h3, 1'b0)});
    for (int h = 0; h < 4; h++)
      for (int m = 0; m < 16; m++)
        run(4'(m), h);   // R6 H=0 counts as 1; R10 bus 3 absent
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule